// File: doc/BRIEF.md
# HDLC Receive Frame Assembler

This block sits behind an HDLC receiver that has already removed flags, checked the CRC and parked the received bytes in a small show-ahead FIFO. It assembles those bytes into whole frames. The receiver raises an event each time a chunk of data is ready to collect. "Pool full" means a complete pool of bytes is waiting. "Message end" means the frame has finished, and it comes with a residual byte count and a status nibble. "Overflow" means the receiver lost data. The assembler copies each chunk into a local frame buffer. It then pulses a receive-message-complete acknowledge so that the receiver releases the chunk.

When a frame ends, the assembler checks the status nibble. It hands a good frame to a valid/ready byte stream, with a last flag on the final byte. Bad frames, frames that would overrun the buffer and empty frames are dropped. Two status formats are supported. In the plain format the status comes only through the event. In the trailing format the status must also show a valid frame, and the final byte received is a status byte that is removed from the delivered frame.

Top module: `hdlc_rx_assembler`

## Requirements
- R1: When a pool-full event is accepted and the buffer has room, `fifo_rd` is high for exactly POOL (32) consecutive cycles, and `rmc` then pulses for one cycle in the cycle right after the last read.
- R2: On a message-end event, the number of bytes drained is `evt_count` (5 bits), where the value 0 stands for 32.
- R3: With `status_fmt`=0, a message-end is accepted only when `evt_status[2:0]` (bit2 overflow, bit1 CRC good, bit0 abort) equals 3'b010. `evt_status[3]` is ignored.
- R4: With `status_fmt`=1, a message-end is accepted only when `evt_status[3:0]` equals 4'b1010 (bit3 valid frame). The last byte drained is dropped from the delivered frame.
- R5: A rejected message-end performs no FIFO read, pulses `rmc` once in the cycle after the event and delivers nothing. The bytes collected so far for that frame are discarded.
- R6: If the bytes already held plus the chunk size would be MAX_LEN or more, the chunk is not read, `rmc` pulses once in the cycle after the event, and the held bytes are discarded.
- R7: An accepted frame whose final length is below 1 is not delivered. After every message-end the next frame starts empty.
- R8: An overflow event (`evt_kind` bit 1 set) pulses `rmc` once in the cycle after the event. It reads nothing and keeps the bytes already held.
- R9: A delivered frame appears on `out_data` in arrival order, with `out_last` on its final byte only. While `out_valid` is high and `out_ready` is low, the data and flag are held.
- R10: After reset `evt_ready` is 1 and `fifo_rd`, `rmc` and `out_valid` are 0. `evt_ready` is 0 whenever the block is reading, acknowledging or delivering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_fmt | input | 1 | 0: plain status, 1: trailing status byte format |
| evt_valid | input | 1 | Receiver event present |
| evt_ready | output | 1 | Block idle and able to take an event |
| evt_kind | input | 2 | 0 pool full, 1 message end, 2 or 3 overflow |
| evt_status | input | 4 | Frame status nibble for message end |
| evt_count | input | CW | Residual byte count for message end, 0 = POOL |
| fifo_rd | output | 1 | Pops one byte from the receive FIFO |
| fifo_dout | input | DW | Head byte of the receive FIFO (show-ahead) |
| rmc | output | 1 | Receive-message-complete acknowledge pulse |
| out_valid | output | 1 | Frame byte valid |
| out_ready | input | 1 | Sink accepts the byte |
| out_data | output | DW | Frame byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
Each event is accepted at a clock edge E. If the chunk is drained, its n FIFO reads happen at the n edges after E, and `rmc` is seen at edge E+n+1. A discard or an overflow event gives `rmc` at edge E+1. Frame bytes start one edge after that. The bench records the edge of each accepted event and of each `rmc` pulse, and checks the difference against n+1 taken from its own model. It counts reads and frames only after the block has returned idle, and it samples everything on the falling edge. A fixed-seed random mix of events, statuses, counts, formats and sink backpressure follows directed cases at the buffer-length boundary.

// File: rtl/hdlc_rx_assembler.sv
module hdlc_rx_assembler #(
  parameter int MAX_LEN = 300,
  parameter int POOL    = 32,
  parameter int DW      = 8,
  parameter int CW      = $clog2(POOL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          status_fmt,
  input  logic          evt_valid,
  output logic          evt_ready,
  input  logic [1:0]    evt_kind,
  input  logic [3:0]    evt_status,
  input  logic [CW-1:0] evt_count,
  output logic          fifo_rd,
  input  logic [DW-1:0] fifo_dout,
  output logic          rmc,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_last
);
  localparam int IW = $clog2(MAX_LEN + POOL + 1);
  localparam int AW = $clog2(MAX_LEN);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_ACK, S_SEND} st_t;
  st_t st;

  logic [DW-1:0] mem [MAX_LEN];
  logic [IW-1:0] wr_idx, rd_idx, left, len_q;
  logic          dlv, strip;

  wire is_pf = evt_kind == 2'd0;
  wire is_me = evt_kind == 2'd1;
  wire is_ov = evt_kind[1];
  wire stat_ok = status_fmt ? (evt_status == 4'b1010) : (evt_status[2:0] == 3'b010);
  wire [IW-1:0] res_n = (evt_count == '0) ? IW'(POOL) : IW'(evt_count);
  wire [IW-1:0] need  = is_pf ? IW'(POOL) : res_n;
  wire fits    = (wr_idx + need) < IW'(MAX_LEN);
  wire do_read = (is_pf || (is_me && stat_ok)) && fits;
  wire [IW-1:0] final_len = wr_idx - IW'(strip);

  assign evt_ready = st == S_IDLE;
  assign fifo_rd   = st == S_DRAIN;
  assign rmc       = st == S_ACK;
  assign out_valid = st == S_SEND;
  assign out_last  = out_valid && (rd_idx == len_q - IW'(1));
  assign out_data  = mem[rd_idx[AW-1:0]];

  always_ff @(posedge clk)
    if (fifo_rd) mem[wr_idx[AW-1:0]] <= fifo_dout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wr_idx <= '0;
      rd_idx <= '0;
      left   <= '0;
      len_q  <= '0;
      dlv    <= 1'b0;
      strip  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (evt_valid) begin
          dlv   <= is_me && do_read;
          strip <= status_fmt;
          if (do_read) begin
            left <= need;
            st   <= S_DRAIN;
          end else begin
            if (!is_ov) wr_idx <= '0;
            st <= S_ACK;
          end
        end
        S_DRAIN: begin
          wr_idx <= wr_idx + IW'(1);
          left   <= left - IW'(1);
          if (left == IW'(1)) st <= S_ACK;
        end
        S_ACK: begin
          dlv <= 1'b0;
          st  <= S_IDLE;
          if (dlv) begin
            len_q  <= final_len;
            rd_idx <= '0;
            wr_idx <= '0;
            if (wr_idx > IW'(strip)) st <= S_SEND;
          end
        end
        S_SEND: if (out_ready) begin
          rd_idx <= rd_idx + IW'(1);
          if (out_last) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1
  rmc_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fifo_rd) |-> rmc);
  // R1
  rmc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rmc |=> !rmc);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
  // R9
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);
  // R10
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rd || rmc || out_valid) |-> !evt_ready);
  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_idx < IW'(MAX_LEN));
endmodule

// File: tb/hdlc_rx_assembler_tb_top.sv
module hdlc_rx_assembler_tb_top;
  localparam int MAXL = 300;
  localparam int POOL = 32;
  localparam int CW   = 5;

  logic clk = 0, rst_n = 0;
  logic status_fmt = 0, evt_valid = 0, out_ready = 1;
  logic [1:0] evt_kind = 0;
  logic [3:0] evt_status = 0;
  logic [CW-1:0] evt_count = 0;
  logic [7:0] fifo_dout, out_data;
  logic evt_ready, fifo_rd, rmc, out_valid, out_last;

  always #10 clk = ~clk;

  hdlc_rx_assembler #(.MAX_LEN(MAXL), .POOL(POOL), .DW(8), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .status_fmt(status_fmt),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_kind(evt_kind),
    .evt_status(evt_status), .evt_count(evt_count),
    .fifo_rd(fifo_rd), .fifo_dout(fifo_dout), .rmc(rmc),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last));

  function automatic logic [7:0] src_byte(int k);
    return 8'((k * 97) ^ (k >>> 5) ^ 90);
  endfunction

  int rd_ptr = 0, rmc_cnt = 0, frames = 0, cyc = 0, ev_cyc = 0, rmc_cyc = 0;
  logic [7:0] got_q[$];
  assign fifo_dout = src_byte(rd_ptr);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n) begin
      if (fifo_rd) rd_ptr <= rd_ptr + 1;
      if (rmc) begin rmc_cnt <= rmc_cnt + 1; rmc_cyc <= cyc; end
      if (evt_valid && evt_ready) ev_cyc <= cyc;
      if (out_valid && out_ready) begin
        got_q.push_back(out_data);
        if (out_last) frames <= frames + 1;
      end
    end
  end

  int checks = 0, failures = 0, bp_en = 0;
  int m_idx = 0, m_rd = 0;
  logic [7:0] m_buf[$];

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit stat_good(bit fmt, logic [3:0] s);
    return fmt ? (s == 4'b1010) : (s[2:0] == 3'b010);
  endfunction

  task automatic run_event(logic [1:0] kind, logic [3:0] st, logic [CW-1:0] cnt, bit fmt, string req);
    int n = 0, len = 0, r0, c0, f0, wait_c = 0, bad = 0;
    bit deliver = 0;
    logic [7:0] exp_f[$];
    if (kind == 0) begin
      if (m_idx + POOL >= MAXL) begin m_idx = 0; m_buf.delete(); end
      else n = POOL;
    end else if (kind == 1) begin
      int c = (cnt == 0) ? POOL : int'(cnt);
      if (!stat_good(fmt, st) || m_idx + c >= MAXL) begin m_idx = 0; m_buf.delete(); end
      else n = c;
    end
    for (int i = 0; i < n; i++) m_buf.push_back(src_byte(m_rd + i));
    m_rd += n; m_idx += n;
    if (kind == 1 && n > 0) begin
      len = m_buf.size() - int'(fmt);
      deliver = len >= 1;
      for (int i = 0; i < len; i++) exp_f.push_back(m_buf[i]);
      m_buf.delete(); m_idx = 0;
    end
    got_q.delete();
    r0 = rd_ptr; c0 = rmc_cnt; f0 = frames;
    @(negedge clk);
    evt_valid = 1; evt_kind = kind; evt_status = st; evt_count = cnt; status_fmt = fmt;
    @(negedge clk);
    evt_valid = 0;
    while (!(evt_ready && !out_valid) && wait_c < 2000) begin
      out_ready = bp_en ? 1'($urandom % 2) : 1'b1;
      @(negedge clk);
      wait_c++;
    end
    out_ready = 1;
    chk(wait_c < 2000, {req, " returns idle"}, wait_c, 0);
    chk(rd_ptr - r0 == n, {req, " read count"}, rd_ptr - r0, n);
    chk(rmc_cnt - c0 == 1, {req, " ack count"}, rmc_cnt - c0, 1);
    chk(rmc_cyc - ev_cyc == n + 1, {req, " ack latency"}, rmc_cyc - ev_cyc, n + 1);
    chk(frames - f0 == int'(deliver), {req, " frames"}, frames - f0, int'(deliver));
    if (deliver) begin
      chk(got_q.size() == len, {req, " R9 length"}, got_q.size(), len);
      for (int i = 0; i < len && i < got_q.size(); i++) if (got_q[i] !== exp_f[i]) bad++;
      chk(bad == 0, {req, " R9 data mismatches"}, bad, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(evt_ready === 1'b1, "R10 evt_ready", evt_ready, 1);
    chk({fifo_rd, rmc, out_valid} === 3'b000, "R10 outputs idle", {fifo_rd, rmc, out_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    run_event(2'd1, 4'b0010, 5'd5, 0, "R3 good plain");
    run_event(2'd1, 4'b1010, 5'd0, 0, "R2 count zero means 32");
    run_event(2'd0, 4'b0000, 5'd0, 0, "R1 pool full");
    run_event(2'd1, 4'b0010, 5'd3, 0, "R1 pool then end");
    run_event(2'd1, 4'b0110, 5'd4, 0, "R5 overflow bit");
    run_event(2'd1, 4'b0011, 5'd4, 0, "R5 abort bit");
    run_event(2'd1, 4'b0000, 5'd4, 0, "R5 crc bad");
    run_event(2'd0, 4'b0000, 5'd0, 0, "R5 pool before reject");
    run_event(2'd1, 4'b0000, 5'd2, 0, "R5 reject");
    run_event(2'd1, 4'b0010, 5'd4, 0, "R5 fresh after reject");
    run_event(2'd1, 4'b1010, 5'd6, 1, "R4 trailing strip");
    run_event(2'd1, 4'b0010, 5'd6, 1, "R4 valid missing");
    run_event(2'd1, 4'b1010, 5'd1, 1, "R7 empty after strip");
    run_event(2'd1, 4'b0010, 5'd2, 0, "R7 starts empty");
    run_event(2'd0, 4'b0000, 5'd0, 0, "R8 pool before overflow");
    run_event(2'd2, 4'b0000, 5'd0, 0, "R8 overflow");
    run_event(2'd3, 4'b0000, 5'd0, 0, "R8 overflow kind3");
    run_event(2'd1, 4'b0010, 5'd2, 0, "R8 held bytes kept");
    for (int i = 0; i < 9; i++) run_event(2'd0, 4'b0, 5'd0, 0, "R6 fill");
    run_event(2'd1, 4'b0010, 5'd12, 0, "R6 reaches max");
    run_event(2'd1, 4'b0010, 5'd4, 0, "R6 fresh after drop");
    for (int i = 0; i < 9; i++) run_event(2'd0, 4'b0, 5'd0, 0, "R6 fill");
    run_event(2'd0, 4'b0, 5'd0, 0, "R6 pool over max");
    for (int i = 0; i < 9; i++) run_event(2'd0, 4'b0, 5'd0, 0, "R6 fill");
    run_event(2'd1, 4'b0010, 5'd11, 0, "R6 one below max");
    bp_en = 1;
    run_event(2'd1, 4'b1010, 5'd9, 1, "R9 backpressure");
    for (int i = 0; i < 150; i++) begin
      int k = $urandom % 10;
      bit f = 1'($urandom % 2);
      logic [3:0] s = ($urandom % 3 == 0) ? 4'($urandom) : (f ? 4'b1010 : 4'b0010);
      run_event(k < 5 ? 2'd0 : (k < 9 ? 2'd1 : 2'd2), s, 5'($urandom), f, "R2 R9 random");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule